// File: doc/BRIEF.md
# Snooping Write-Back Coherence Controller

This block keeps one processor's write-back cache coherent with the other masters on a shared memory bus. Every cache line carries one of three statuses: not present, a read-only copy that matches memory, or an exclusive modified copy. Processor accesses that can finish locally complete in the same cycle. Any access that needs the bus holds the processor stalled while the controller requests the bus from a single arbiter and runs one or more transactions: fetch a read-only copy, invalidate all other copies, or write a modified block back to memory.

While another master owns the bus, the controller watches that master's transactions. When another master fetches a block that this cache holds modified, the cache, not memory, drives the data, and the line falls back to a clean copy. When another master invalidates a block that this cache holds, the line is dropped.

The cache is direct-mapped, with one data word per line. Each bus transaction lasts one cycle: it takes place in the cycle in which the request and the grant are both high. Data for a fetch is presented on the bus read-data input in that same cycle.

Top module: `snoop_cc_ctrl`

## Requirements
- R1: After reset every line is invalid. With no request pending, `cpu_stall`, `bus_req` and `snoop_supply` are low, and the first access to any address misses.
- R2: A processor read whose tag matches a clean or modified line completes in the cycle it is presented. `cpu_stall` stays low, no bus request is made, and `cpu_rdata` returns the line's data.
- R3: A processor write whose tag matches a modified line completes in its first cycle without bus activity. A later read of that address returns the written data.
- R4: A processor write whose tag matches a clean line stalls and issues one bus Invalidate (`bus_op` = 2) to that address. The line then becomes modified and the write completes.
- R5: On a tag miss where the indexed line is modified, the first transaction is a Write (`bus_op` = 3) of the old block's address ({old tag, index}) and its data. The next transaction is a Read of the new address.
- R6: On a tag miss, a Read (`bus_op` = 1) of the requested address fills the line clean with `bus_rdata`. A read then completes with that data. A write instead issues an Invalidate of the same address before it completes.
- R7: A snooped Read (`snoop_op` = 1) to a block held modified raises `snoop_supply` in the same cycle and presents the line data on `snoop_data`. The line becomes clean, so the next processor write to it needs an Invalidate.
- R8: A snooped Invalidate (`snoop_op` = 2) to a block held clean or modified makes the line invalid. The next processor access to that address misses.
- R9: A snoop is ignored, with no supply and no status change, if its tag differs from the line's tag, if the line is invalid, or if `bus_gnt` is high in that cycle.
- R10: While a bus request waits for a grant, `cpu_stall` stays high. A transaction takes place only in a cycle where `bus_req` and `bus_gnt` are both high. The address split is index = `addr[IDX_W-1:0]` and tag = the upper bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor access request, held until not stalled |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Processor word address |
| cpu_wdata | input | DATA_W | Processor write data |
| cpu_rdata | output | DATA_W | Read data, valid when the request is not stalled |
| cpu_stall | output | 1 | Processor must hold its request |
| bus_req | output | 1 | Bus request to the arbiter |
| bus_gnt | input | 1 | Bus grant; also marks this controller as bus master |
| bus_op | output | 2 | 0 none, 1 Read, 2 Invalidate, 3 Write |
| bus_addr | output | ADDR_W | Transaction address |
| bus_wdata | output | DATA_W | Write-back data |
| bus_rdata | input | DATA_W | Data returned for a Read in the grant cycle |
| snoop_valid | input | 1 | Another master's transaction is on the bus |
| snoop_op | input | 2 | Snooped operation, same encoding as `bus_op` |
| snoop_addr | input | ADDR_W | Snooped address |
| snoop_supply | output | 1 | This cache supplies the data of a snooped Read |
| snoop_data | output | DATA_W | Supplied block data |

## Verification
The assertions check four rules on every cycle: a pending request always stalls the processor, a granted write-back is always followed by a Read request, a granted Invalidate or Read leaves the line modified or clean, and a snoop status update lands in the line it addressed. Only the bench's scenarios can show that the whole sequence of transactions for each access is right, with correct addresses and data. They also show that a line demoted or dropped by a snoop changes how the next processor access behaves, and that snoops arriving while the bus is granted leave a modified line able to supply data afterwards.

// File: rtl/snoop_cc_pkg.sv
package snoop_cc_pkg;
   typedef enum logic [1:0] {
      LS_INV   = 2'd0,
      LS_CLEAN = 2'd1,
      LS_DIRTY = 2'd2
   } line_st_t;

   typedef enum logic [1:0] {
      BOP_NONE  = 2'd0,
      BOP_READ  = 2'd1,
      BOP_INVAL = 2'd2,
      BOP_WRITE = 2'd3
   } bus_op_t;
endpackage

// File: rtl/scc_line_store.sv
module scc_line_store
   import snoop_cc_pkg::*;
#(
   parameter int LINES  = 16,
   parameter int TAG_W  = 4,
   parameter int DATA_W = 16
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [$clog2(LINES)-1:0]   a_idx,
   output line_st_t                   a_st,
   output logic [TAG_W-1:0]           a_tag,
   output logic [DATA_W-1:0]          a_dat,
   input  logic [$clog2(LINES)-1:0]   b_idx,
   output line_st_t                   b_st,
   output logic [TAG_W-1:0]           b_tag,
   output logic [DATA_W-1:0]          b_dat,
   input  logic                       wa_en,
   input  logic [$clog2(LINES)-1:0]   wa_idx,
   input  line_st_t                   wa_st,
   input  logic [TAG_W-1:0]           wa_tag,
   input  logic [DATA_W-1:0]          wa_dat,
   input  logic                       wb_en,
   input  logic [$clog2(LINES)-1:0]   wb_idx,
   input  line_st_t                   wb_st
);
   localparam int IDX_W = $clog2(LINES);

   line_st_t            st_all  [LINES];
   logic [TAG_W-1:0]    tag_all [LINES];
   logic [DATA_W-1:0]   dat_all [LINES];

   for (genvar g = 0; g < LINES; g++) begin : g_line
      line_st_t            st_r;
      logic [TAG_W-1:0]    tag_r;
      logic [DATA_W-1:0]   dat_r;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            st_r  <= LS_INV;
            tag_r <= '0;
            dat_r <= '0;
         end else if (wa_en && wa_idx == IDX_W'(g)) begin
            st_r  <= wa_st;
            tag_r <= wa_tag;
            dat_r <= wa_dat;
         end else if (wb_en && wb_idx == IDX_W'(g)) begin
            st_r  <= wb_st;
         end
      end

      assign st_all[g]  = st_r;
      assign tag_all[g] = tag_r;
      assign dat_all[g] = dat_r;
   end

   assign a_st  = st_all[a_idx];
   assign a_tag = tag_all[a_idx];
   assign a_dat = dat_all[a_idx];
   assign b_st  = st_all[b_idx];
   assign b_tag = tag_all[b_idx];
   assign b_dat = dat_all[b_idx];

   // R7 R8
   snoop_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_en && !(wa_en && wa_idx == wb_idx)) |=> (st_all[$past(wb_idx)] == $past(wb_st)));
endmodule

// File: rtl/scc_snoop.sv
module scc_snoop
   import snoop_cc_pkg::*;
#(
   parameter int TAG_W  = 4,
   parameter int DATA_W = 16
) (
   input  logic               snp_valid,
   input  bus_op_t            snp_op,
   input  logic [TAG_W-1:0]   snp_tag,
   input  logic               bus_gnt,
   input  line_st_t           line_st,
   input  logic [TAG_W-1:0]   line_tag,
   input  logic [DATA_W-1:0]  line_dat,
   output logic               hit,
   output logic               supply,
   output logic [DATA_W-1:0]  sdata,
   output logic               upd_en,
   output line_st_t           upd_st
);
   logic active;

   assign active = snp_valid && !bus_gnt;
   assign hit    = active && (line_st != LS_INV) && (line_tag == snp_tag);
   assign supply = hit && (snp_op == BOP_READ) && (line_st == LS_DIRTY);
   assign sdata  = line_dat;

   always_comb begin
      upd_en = 1'b0;
      upd_st = line_st;
      if (supply) begin
         upd_en = 1'b1;
         upd_st = LS_CLEAN;
      end else if (hit && snp_op == BOP_INVAL) begin
         upd_en = 1'b1;
         upd_st = LS_INV;
      end
   end
endmodule

// File: rtl/scc_master.sv
module scc_master
   import snoop_cc_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 16,
   parameter int IDX_W  = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       cpu_req,
   input  logic                       cpu_we,
   input  logic [ADDR_W-1:0]          cpu_addr,
   input  logic [DATA_W-1:0]          cpu_wdata,
   output logic                       cpu_stall,
   input  logic                       snoop_blk,
   input  line_st_t                   line_st,
   input  logic [ADDR_W-IDX_W-1:0]    line_tag,
   input  logic [DATA_W-1:0]          line_dat,
   output logic                       bus_req,
   input  logic                       bus_gnt,
   output bus_op_t                    bus_op,
   output logic [ADDR_W-1:0]          bus_addr,
   output logic [DATA_W-1:0]          bus_wdata,
   input  logic [DATA_W-1:0]          bus_rdata,
   output logic                       wa_en,
   output line_st_t                   wa_st,
   output logic [ADDR_W-IDX_W-1:0]    wa_tag,
   output logic [DATA_W-1:0]          wa_dat
);
   localparam int TAG_W = ADDR_W - IDX_W;

   typedef enum logic [1:0] {M_IDLE, M_WB, M_RD, M_INV} mst_t;
   mst_t state_q, state_d;

   logic [TAG_W-1:0] req_tag;
   logic [IDX_W-1:0] req_idx;
   logic line_hit, done, wb_live, rd_live, inv_live;

   assign req_tag  = cpu_addr[ADDR_W-1:IDX_W];
   assign req_idx  = cpu_addr[IDX_W-1:0];
   assign line_hit = (line_st != LS_INV) && (line_tag == req_tag);

   assign done     = cpu_req && (state_q == M_IDLE) && line_hit && !snoop_blk
                     && (!cpu_we || line_st == LS_DIRTY);
   assign cpu_stall = cpu_req && !done;

   assign wb_live  = (state_q == M_WB)  && (line_st == LS_DIRTY);
   assign rd_live  = (state_q == M_RD);
   assign inv_live = (state_q == M_INV) && line_hit && (line_st == LS_CLEAN);
   assign bus_req  = wb_live || rd_live || inv_live;

   always_comb begin
      bus_op    = BOP_NONE;
      bus_addr  = cpu_addr;
      bus_wdata = line_dat;
      if (wb_live) begin
         bus_op   = BOP_WRITE;
         bus_addr = {line_tag, req_idx};
      end else if (rd_live) begin
         bus_op   = BOP_READ;
      end else if (inv_live) begin
         bus_op   = BOP_INVAL;
      end
   end

   always_comb begin
      wa_en  = 1'b0;
      wa_st  = line_st;
      wa_tag = line_tag;
      wa_dat = line_dat;
      if (done && cpu_we) begin
         wa_en  = 1'b1;
         wa_st  = LS_DIRTY;
         wa_dat = cpu_wdata;
      end else if (bus_gnt && wb_live) begin
         wa_en  = 1'b1;
         wa_st  = LS_INV;
      end else if (bus_gnt && rd_live) begin
         wa_en  = 1'b1;
         wa_st  = LS_CLEAN;
         wa_tag = req_tag;
         wa_dat = bus_rdata;
      end else if (bus_gnt && inv_live) begin
         wa_en  = 1'b1;
         wa_st  = LS_DIRTY;
      end
   end

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         M_IDLE: if (cpu_req && !done && !snoop_blk) begin
            if (!line_hit) state_d = (line_st == LS_DIRTY) ? M_WB : M_RD;
            else           state_d = M_INV;
         end
         M_WB:   if (!wb_live || bus_gnt) state_d = M_RD;
         M_RD:   if (bus_gnt) state_d = M_IDLE;
         M_INV:  if (!inv_live || bus_gnt) state_d = M_IDLE;
         default: state_d = M_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= M_IDLE;
      else        state_q <= state_d;
   end

   // R10
   req_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req |-> cpu_stall);

   // R5
   wb_then_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_gnt && bus_op == BOP_WRITE) |=> (bus_req && bus_op == BOP_READ));

   // R4
   inv_dirty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(bus_req && bus_gnt && bus_op == BOP_INVAL) && cpu_req && $stable(cpu_addr))
      |-> (line_hit && line_st == LS_DIRTY));

   // R6
   fill_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(bus_req && bus_gnt && bus_op == BOP_READ) && cpu_req && $stable(cpu_addr))
      |-> (line_hit && line_st == LS_CLEAN));
endmodule

// File: rtl/snoop_cc_ctrl.sv
module snoop_cc_ctrl
   import snoop_cc_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 16,
   parameter int LINES  = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cpu_req,
   input  logic               cpu_we,
   input  logic [ADDR_W-1:0]  cpu_addr,
   input  logic [DATA_W-1:0]  cpu_wdata,
   output logic [DATA_W-1:0]  cpu_rdata,
   output logic               cpu_stall,
   output logic               bus_req,
   input  logic               bus_gnt,
   output logic [1:0]         bus_op,
   output logic [ADDR_W-1:0]  bus_addr,
   output logic [DATA_W-1:0]  bus_wdata,
   input  logic [DATA_W-1:0]  bus_rdata,
   input  logic               snoop_valid,
   input  logic [1:0]         snoop_op,
   input  logic [ADDR_W-1:0]  snoop_addr,
   output logic               snoop_supply,
   output logic [DATA_W-1:0]  snoop_data
);
   localparam int IDX_W = $clog2(LINES);
   localparam int TAG_W = ADDR_W - IDX_W;

   initial begin
      param_chk: assert (LINES >= 2 && (LINES & (LINES - 1)) == 0 && ADDR_W > IDX_W && DATA_W > 0)
         else $error("snoop_cc_ctrl: bad parameters");
   end

   logic [IDX_W-1:0]  cpu_idx, snp_idx;
   line_st_t          a_st, b_st, wa_st, upd_st;
   logic [TAG_W-1:0]  a_tag, b_tag, wa_tag;
   logic [DATA_W-1:0] a_dat, b_dat, wa_dat;
   logic              wa_en, upd_en, snp_hit, snoop_blk;
   bus_op_t           op_int;

   assign cpu_idx   = cpu_addr[IDX_W-1:0];
   assign snp_idx   = snoop_addr[IDX_W-1:0];
   assign snoop_blk = snp_hit && (snp_idx == cpu_idx);
   assign cpu_rdata = a_dat;
   assign bus_op    = op_int;

   scc_line_store #(.LINES(LINES), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
      .clk(clk), .rst_n(rst_n),
      .a_idx(cpu_idx), .a_st(a_st), .a_tag(a_tag), .a_dat(a_dat),
      .b_idx(snp_idx), .b_st(b_st), .b_tag(b_tag), .b_dat(b_dat),
      .wa_en(wa_en), .wa_idx(cpu_idx), .wa_st(wa_st), .wa_tag(wa_tag), .wa_dat(wa_dat),
      .wb_en(upd_en), .wb_idx(snp_idx), .wb_st(upd_st)
   );

   scc_snoop #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_snoop (
      .snp_valid(snoop_valid), .snp_op(bus_op_t'(snoop_op)),
      .snp_tag(snoop_addr[ADDR_W-1:IDX_W]), .bus_gnt(bus_gnt),
      .line_st(b_st), .line_tag(b_tag), .line_dat(b_dat),
      .hit(snp_hit), .supply(snoop_supply), .sdata(snoop_data),
      .upd_en(upd_en), .upd_st(upd_st)
   );

   scc_master #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_master (
      .clk(clk), .rst_n(rst_n),
      .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
      .cpu_stall(cpu_stall), .snoop_blk(snoop_blk),
      .line_st(a_st), .line_tag(a_tag), .line_dat(a_dat),
      .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_op(op_int), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .wa_en(wa_en), .wa_st(wa_st), .wa_tag(wa_tag), .wa_dat(wa_dat)
   );
endmodule

// File: tb/snoop_cc_ctrl_tb.sv
`timescale 1ns/1ps
module snoop_cc_ctrl_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cpu_req = 1'b0, cpu_we = 1'b0;
   logic [7:0]  cpu_addr = '0;
   logic [15:0] cpu_wdata = '0, cpu_rdata;
   logic        cpu_stall, bus_req;
   logic        bus_gnt = 1'b0;
   logic [1:0]  bus_op;
   logic [7:0]  bus_addr;
   logic [15:0] bus_wdata, bus_rdata;
   logic        snoop_valid = 1'b0;
   logic [1:0]  snoop_op = '0;
   logic [7:0]  snoop_addr = '0;
   logic        snoop_supply;
   logic [15:0] snoop_data;

   int checks = 0, errors = 0;
   bit finished = 0;
   int lat = 0, wcnt = 0;
   bit force_gnt = 0;

   int          ref_st  [16];
   int          ref_tag [16];
   logic [15:0] ref_dat [16];
   logic [15:0] mem     [256];
   int          q_op[$], q_addr[$];
   logic [15:0] q_dat[$];

   always #4 clk = ~clk;

   assign bus_rdata = mem[bus_addr];

   snoop_cc_ctrl u_dut (
      .clk(clk), .rst_n(rst_n),
      .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
      .cpu_rdata(cpu_rdata), .cpu_stall(cpu_stall),
      .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_op(bus_op), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .snoop_valid(snoop_valid), .snoop_op(snoop_op), .snoop_addr(snoop_addr),
      .snoop_supply(snoop_supply), .snoop_data(snoop_data)
   );

   // arbiter: grants after 'lat' waiting cycles
   always @(negedge clk) begin
      #1;
      if (force_gnt) bus_gnt = 1'b1;
      else if (bus_req && wcnt >= lat) begin bus_gnt = 1'b1; wcnt = 0; end
      else begin bus_gnt = 1'b0; if (bus_req) wcnt++; end
   end

   task automatic chk(input bit ok, input string rq, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
      end
   endtask

   task automatic push(input int op, input int a, input logic [15:0] d);
      q_op.push_back(op); q_addr.push_back(a); q_dat.push_back(d);
   endtask

   task automatic cpu_access(input bit we, input int addr, input logic [15:0] wd, input string rq);
      int idx, tg, cyc, op, a;
      bit hit, local_done, fin;
      logic [15:0] exp_rd, d;
      idx = addr & 15; tg = addr >> 4;
      q_op.delete(); q_addr.delete(); q_dat.delete();
      hit = (ref_st[idx] != 0) && (ref_tag[idx] == tg);
      local_done = hit && !(we && ref_st[idx] == 1);
      exp_rd = 16'h0;
      if (hit) begin
         exp_rd = ref_dat[idx];
         if (we && ref_st[idx] == 1) push(2, addr, 16'h0);
      end else begin
         if (ref_st[idx] == 2) push(3, (ref_tag[idx] << 4) | idx, ref_dat[idx]);
         push(1, addr, 16'h0);
         exp_rd = mem[addr];
         if (we) push(2, addr, 16'h0);
      end
      if (we) begin ref_st[idx] = 2; ref_tag[idx] = tg; ref_dat[idx] = wd; end
      else if (!hit) begin ref_st[idx] = 1; ref_tag[idx] = tg; ref_dat[idx] = exp_rd; end

      @(negedge clk);
      cpu_req = 1'b1; cpu_we = we; cpu_addr = 8'(addr); cpu_wdata = wd;
      cyc = 0; fin = 0;
      while (!fin) begin
         #2;
         if (bus_req) chk(cpu_stall == 1'b1, "R10", "stall while request pending", cpu_stall, 1);
         if (bus_req && bus_gnt) begin
            if (q_op.size() == 0) chk(1'b0, rq, "unexpected bus op", bus_op, 0);
            else begin
               op = q_op.pop_front(); a = q_addr.pop_front(); d = q_dat.pop_front();
               chk(bus_op == 2'(op), rq, "bus op", bus_op, op);
               chk(bus_addr == 8'(a), rq, "bus addr", bus_addr, a);
               if (op == 3) begin
                  chk(bus_wdata == d, rq, "writeback data", bus_wdata, d);
                  mem[bus_addr] = bus_wdata;
               end
            end
         end
         if (!cpu_stall) begin
            chk(q_op.size() == 0, rq, "missing bus ops", q_op.size(), 0);
            if (!we) chk(cpu_rdata == exp_rd, rq, "read data", cpu_rdata, exp_rd);
            if (local_done) chk(cyc == 0, rq, "local completion cycles", cyc, 0);
            fin = 1;
         end else begin
            cyc++;
            if (cyc > 60) begin
               chk(1'b0, rq, "access never completed", cyc, 60);
               fin = 1;
            end else @(negedge clk);
         end
      end
      @(negedge clk);
      cpu_req = 1'b0;
   endtask

   task automatic snoop(input int op, input int addr, input bit fg, input string rq);
      int idx, tg;
      bit hit, sup;
      idx = addr & 15; tg = addr >> 4;
      @(negedge clk);
      force_gnt = fg; snoop_valid = 1'b1; snoop_op = 2'(op); snoop_addr = 8'(addr);
      #2;
      hit = !fg && (ref_st[idx] != 0) && (ref_tag[idx] == tg);
      sup = hit && (op == 1) && (ref_st[idx] == 2);
      chk(snoop_supply == sup, rq, "snoop supply", snoop_supply, sup);
      if (sup) begin
         chk(snoop_data == ref_dat[idx], rq, "snoop data", snoop_data, ref_dat[idx]);
         mem[addr] = ref_dat[idx];
         ref_st[idx] = 1;
      end else if (hit && op == 2) ref_st[idx] = 0;
      @(negedge clk);
      snoop_valid = 1'b0; force_gnt = 1'b0;
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      end
   endtask

   initial begin
      #(8 * 150000);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      logic [15:0] lf;
      int r, a;
      for (int i = 0; i < 256; i++) mem[i] = 16'(i * 97 + 3);
      for (int i = 0; i < 16; i++) begin ref_st[i] = 0; ref_tag[i] = 0; ref_dat[i] = '0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk); #2;
      chk(cpu_stall == 1'b0, "R1", "stall after reset", cpu_stall, 0);
      chk(bus_req == 1'b0, "R1", "bus_req after reset", bus_req, 0);
      chk(snoop_supply == 1'b0, "R1", "supply after reset", snoop_supply, 0);

      cpu_access(0, 'h05, 16'h0, "R1");          // first access misses
      cpu_access(0, 'h05, 16'h0, "R2");          // clean read hit
      cpu_access(1, 'h05, 16'hA5A5, "R4");       // write to clean line
      cpu_access(1, 'h05, 16'h1234, "R3");       // write to dirty line
      cpu_access(0, 'h05, 16'h0, "R3");          // reads written value, dirty read hit
      lat = 2;
      cpu_access(1, 'h15, 16'hBEEF, "R5");       // dirty victim then read, inval
      cpu_access(0, 'h33, 16'h0, "R6");          // read miss with latency
      lat = 0;
      snoop(1, 'h15, 0, "R7");                   // dirty owner supplies
      cpu_access(1, 'h15, 16'h7777, "R7");       // demoted line needs invalidate
      snoop(2, 'h15, 0, "R8");                   // invalidate kills line
      cpu_access(0, 'h15, 16'h0, "R8");          // next access misses
      cpu_access(1, 'h26, 16'h4242, "R6");       // write miss: read then invalidate
      snoop(1, 'h36, 0, "R9");                   // other tag
      snoop(2, 'h07, 0, "R9");                   // invalid line
      snoop(2, 'h26, 1, "R9");                   // while granted
      snoop(1, 'h26, 0, "R9");                   // still dirty: supplies

      lf = 16'hACE1;
      for (int n = 0; n < 400; n++) begin
         lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
         r = int'(lf);
         a = (((r >> 4) & 3) << 4) | (r & 3);
         lat = (r >> 8) % 3;
         case ((r >> 10) & 15)
            0, 1, 2, 3, 4, 5: cpu_access(0, a, 16'h0, "R2");
            6, 7, 8, 9:       cpu_access(1, a, lf ^ 16'h5A5A, "R3");
            10, 11, 12:       snoop(1, a, 0, "R7");
            13, 14:           snoop(2, a, 0, "R8");
            default:          snoop(2, a, 1, "R9");
         endcase
      end
      summary();
      $finish;
   end
endmodule